// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit carries out the length-type field of a 64-bit prefixed vector instruction. It keeps a local loop-state word that holds a maximum vector length, a current vector length and the source and destination element offsets. When a request arrives, the unit decodes the 12-bit field into one of five actions: leave the state alone, set the length from an immediate, set it from a scalar register, set both lengths at once, or set only the maximum and clamp the current length to it.

A request is a one-cycle strobe with the field. In register mode the unit reads the scalar register file through a read port with one cycle of latency. One cycle after the read it updates the state word, may write the new length into a scalar register through a write port, and pulses done. An illegal request pulses done together with an illegal flag and leaves the state and the register file untouched. A parameter removes length-type support. In that build every nonzero field is illegal.

Top module: `vl_set_unit`

## Requirements
- R1: After reset the state word is zero, and done, illegal and the register write enable are low. The state word holds maximum length in bits 5:0, current length in 11:6, source offset in 17:12, destination offset in 23:18, sub-length in 25:24 and sub-offset in 27:26.
- R2: A request taken at clock edge N yields a one-cycle done pulse in the cycle after edge N+1. Illegal is high only while done is high. The read address is field bits 5:1, driven in the same cycle as the request.
- R3: An all-zero field completes with done, without illegal, without a register write and with the state unchanged.
- R4: Bit 11 = 0 and bit 0 = 0 (field nonzero): the current length becomes bits 5:1 plus one. The maximum length is kept.
- R5: Bit 11 = 0 and bit 0 = 1: the current length becomes the smaller of the scalar register named by bits 5:1 and the maximum length. If bits 5:1 name register 0 the request is illegal.
- R6: Bit 11 = 1 and bit 0 = 0: the maximum and current lengths both become bits 5:1 plus one.
- R7: Bit 11 = 1 and bit 0 = 1: the maximum length becomes bits 5:1 plus one. The current length is lowered to it if larger, and is otherwise kept.
- R8: If an immediate mode would set a length above XLEN, the request is illegal. The state is unchanged and nothing is written.
- R9: A legal nonzero request writes the new current length, zero-extended, to the scalar register named by bits 10:6. No write is made when that field is zero.
- R10: Source and destination offsets are zero after any length update. Bits 31:24 of the state word read as zero.
- R11: With length-type support disabled, any nonzero field is illegal and changes nothing. An all-zero field still completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| ltype_i | input | 12 | Length-type field |
| rf_rd_en_o | output | 1 | Scalar register read enable (register mode) |
| rf_rd_addr_o | output | 5 | Scalar register read address |
| rf_rd_data_i | input | XLEN | Read data, one cycle after the address |
| rf_wr_en_o | output | 1 | Scalar register write enable |
| rf_wr_addr_o | output | 5 | Scalar register write address |
| rf_wr_data_o | output | XLEN | New current length, zero-extended |
| state_o | output | 32 | Local loop-state word |
| done_o | output | 1 | Request completed |
| illegal_o | output | 1 | Request was illegal |

## Verification
The hardest case to reach is the clamp in maximum-only mode. It needs the current length to be above, equal to or below the new maximum. To set that up, the bench sends a loop-mode request before every maximum-only request, so the current length steps across the whole range while the immediate sweeps all 32 values. Register mode is reached the same way. The bench preloads the model register file with values on both sides of a known maximum, then reads every register, including register 0. The length trap is exercised by building the bench with a small XLEN, so that half of every immediate sweep lands above it.

// File: rtl/vls_pkg.sv
package vls_pkg;
   localparam int LT_W  = 12;
   localparam int RA_W  = 5;
   localparam int LEN_W = 6;

   typedef struct packed {
      logic [3:0]       rsvd;
      logic [1:0]       sub_off;
      logic [1:0]       sub_len;
      logic [LEN_W-1:0] dst_off;
      logic [LEN_W-1:0] src_off;
      logic [LEN_W-1:0] cur_len;
      logic [LEN_W-1:0] max_len;
   } loop_state_t;

   typedef enum logic [2:0] {
      LM_NONE,
      LM_LOOP_IMM,
      LM_LOOP_REG,
      LM_ONEOFF,
      LM_MAXONLY
   } len_mode_e;
endpackage

// File: rtl/vls_decode.sv
module vls_decode
   import vls_pkg::*;
#(
   parameter bit ENABLE = 1'b1
) (
   input  logic [LT_W-1:0] lt_i,
   output len_mode_e       mode_o,
   output logic [RA_W-1:0] imm_o,
   output logic [RA_W-1:0] dst_o,
   output logic            bad_o
);
   assign imm_o = lt_i[RA_W:1];
   assign dst_o = lt_i[2*RA_W:RA_W+1];

   generate
      if (ENABLE) begin : g_on
         always_comb begin
            if (lt_i == '0)         mode_o = LM_NONE;
            else if (!lt_i[LT_W-1]) mode_o = lt_i[0] ? LM_LOOP_REG : LM_LOOP_IMM;
            else                    mode_o = lt_i[0] ? LM_MAXONLY  : LM_ONEOFF;
            bad_o = (mode_o == LM_LOOP_REG) && (lt_i[RA_W:1] == '0);
         end
      end else begin : g_off
         assign mode_o = LM_NONE;
         assign bad_o  = |lt_i;
      end
   endgenerate
endmodule

// File: rtl/vls_compute.sv
module vls_compute
   import vls_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  len_mode_e        mode_i,
   input  logic [RA_W-1:0]  imm_i,
   input  logic [XLEN-1:0]  reg_val_i,
   input  loop_state_t      cur_i,
   output loop_state_t      nxt_o,
   output logic [LEN_W-1:0] new_len_o,
   output logic             trap_o,
   output logic             upd_o
);
   localparam int unsigned LIMIT = XLEN;

   logic [LEN_W-1:0] imm_len;
   logic             too_big;

   assign imm_len = {1'b0, imm_i} + LEN_W'(1);
   assign too_big = 32'(imm_len) > LIMIT;

   always_comb begin
      nxt_o  = cur_i;
      trap_o = 1'b0;
      upd_o  = 1'b1;
      unique case (mode_i)
         LM_LOOP_IMM: begin
            nxt_o.cur_len = imm_len;
            trap_o        = too_big;
         end
         LM_LOOP_REG: begin
            nxt_o.cur_len = (reg_val_i < XLEN'(cur_i.max_len)) ?
                            reg_val_i[LEN_W-1:0] : cur_i.max_len;
         end
         LM_ONEOFF: begin
            nxt_o.max_len = imm_len;
            nxt_o.cur_len = imm_len;
            trap_o        = too_big;
         end
         LM_MAXONLY: begin
            nxt_o.max_len = imm_len;
            nxt_o.cur_len = (cur_i.cur_len > imm_len) ? imm_len : cur_i.cur_len;
            trap_o        = too_big;
         end
         default: upd_o = 1'b0;
      endcase
      if (upd_o) begin
         nxt_o.src_off = '0;
         nxt_o.dst_off = '0;
      end
      new_len_o = nxt_o.cur_len;
   end
endmodule

// File: rtl/vl_set_unit.sv
module vl_set_unit
   import vls_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter bit ENABLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid_i,
   input  logic [11:0]     ltype_i,
   output logic            rf_rd_en_o,
   output logic [4:0]      rf_rd_addr_o,
   input  logic [XLEN-1:0] rf_rd_data_i,
   output logic            rf_wr_en_o,
   output logic [4:0]      rf_wr_addr_o,
   output logic [XLEN-1:0] rf_wr_data_o,
   output logic [31:0]     state_o,
   output logic            done_o,
   output logic            illegal_o
);
   initial begin
      if (XLEN < 8 || XLEN > 1024) $error("vl_set_unit: XLEN out of range");
      if ($bits(loop_state_t) != 32) $error("vl_set_unit: state word must be 32 bits");
   end

   len_mode_e        dec_mode, s1_mode;
   logic [RA_W-1:0]  dec_imm, dec_dst, s1_imm, s1_dst;
   logic             dec_bad, s1_bad, s1_valid;
   loop_state_t      state_q, nxt_state;
   logic [LEN_W-1:0] new_len;
   logic             trap, upd;

   vls_decode #(.ENABLE(ENABLE)) u_dec (
      .lt_i   (ltype_i),
      .mode_o (dec_mode),
      .imm_o  (dec_imm),
      .dst_o  (dec_dst),
      .bad_o  (dec_bad)
   );

   assign rf_rd_en_o   = req_valid_i && (dec_mode == LM_LOOP_REG) && !dec_bad;
   assign rf_rd_addr_o = dec_imm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_mode  <= LM_NONE;
         s1_imm   <= '0;
         s1_dst   <= '0;
         s1_bad   <= 1'b0;
      end else begin
         s1_valid <= req_valid_i;
         if (req_valid_i) begin
            s1_mode <= dec_mode;
            s1_imm  <= dec_imm;
            s1_dst  <= dec_dst;
            s1_bad  <= dec_bad;
         end
      end
   end

   vls_compute #(.XLEN(XLEN)) u_cmp (
      .mode_i    (s1_mode),
      .imm_i     (s1_imm),
      .reg_val_i (rf_rd_data_i),
      .cur_i     (state_q),
      .nxt_o     (nxt_state),
      .new_len_o (new_len),
      .trap_o    (trap),
      .upd_o     (upd)
   );

   logic commit;
   assign commit = s1_valid && upd && !s1_bad && !trap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= '0;
         done_o       <= 1'b0;
         illegal_o    <= 1'b0;
         rf_wr_en_o   <= 1'b0;
         rf_wr_addr_o <= '0;
         rf_wr_data_o <= '0;
      end else begin
         done_o     <= s1_valid;
         illegal_o  <= s1_valid && (s1_bad || trap);
         rf_wr_en_o <= commit && (s1_dst != '0);
         if (commit) begin
            state_q      <= nxt_state;
            rf_wr_addr_o <= s1_dst;
            rf_wr_data_o <= XLEN'(new_len);
         end
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/vls_checker.sv
module vls_checker #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid_i,
   input logic            done_o,
   input logic            illegal_o,
   input logic            rf_wr_en_o,
   input logic [XLEN-1:0] rf_wr_data_o,
   input logic [31:0]     state_o
);
   logic req_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_d <= 1'b0;
      else        req_d <= req_valid_i;
   end

   a_r2_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_d |=> done_o);
   a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !req_d |=> !done_o);
   a_r2_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> done_o);
   a_r8_illegal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> state_o == $past(state_o));
   a_r9_write_carries_len: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en_o |-> done_o && !illegal_o && rf_wr_data_o == XLEN'(state_o[11:6]));
   a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      state_o[31:12] == '0);
   a_r6_max_within_xlen: assert property (@(posedge clk) disable iff (!rst_n)
      32'(state_o[5:0]) <= XLEN);
endmodule

bind vl_set_unit vls_checker #(.XLEN(XLEN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid_i  (req_valid_i),
   .done_o       (done_o),
   .illegal_o    (illegal_o),
   .rf_wr_en_o   (rf_wr_en_o),
   .rf_wr_data_o (rf_wr_data_o),
   .state_o      (state_o)
);

// File: tb/tb_vl_set_unit.sv
module tb_vl_set_unit;
   localparam int CLK_T = 10;
   localparam int XL    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic valid = 1'b0;
   logic [11:0] lt = '0;

   logic          rd_en, wr_en, done, ill;
   logic [4:0]    rd_addr, wr_addr;
   logic [XL-1:0] rd_q, wr_data;
   logic [31:0]   st;

   logic          o_rd_en, o_wr_en, o_done, o_ill;
   logic [4:0]    o_rd_addr, o_wr_addr;
   logic [XL-1:0] o_wr_data;
   logic [31:0]   o_st;

   int total = 0;
   int bad = 0;
   logic [XL-1:0] rf [32];
   int exp_max = 0;
   int exp_vl = 0;

   always #(CLK_T/2) clk = ~clk;

   vl_set_unit #(.XLEN(XL), .ENABLE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(valid), .ltype_i(lt),
      .rf_rd_en_o(rd_en), .rf_rd_addr_o(rd_addr), .rf_rd_data_i(rd_q),
      .rf_wr_en_o(wr_en), .rf_wr_addr_o(wr_addr), .rf_wr_data_o(wr_data),
      .state_o(st), .done_o(done), .illegal_o(ill));

   vl_set_unit #(.XLEN(XL), .ENABLE(1'b0)) dut_off (
      .clk(clk), .rst_n(rst_n), .req_valid_i(valid), .ltype_i(lt),
      .rf_rd_en_o(o_rd_en), .rf_rd_addr_o(o_rd_addr), .rf_rd_data_i('0),
      .rf_wr_en_o(o_wr_en), .rf_wr_addr_o(o_wr_addr), .rf_wr_data_o(o_wr_data),
      .state_o(o_st), .done_o(o_done), .illegal_o(o_ill));

   always @(posedge clk) begin
      if (rd_en) rd_q <= (rd_addr == 0) ? '0 : rf[rd_addr];
      if (wr_en && wr_addr != 0) rf[wr_addr] <= wr_data;
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic run_op(input logic [11:0] f, input string tag);
      int imm, dst, nmax, nvl;
      bit e_ill, e_wr;
      logic [31:0] e_st;
      logic mid_done, after_done;
      imm = int'(f[5:1]);
      dst = int'(f[10:6]);
      nmax = exp_max; nvl = exp_vl; e_ill = 1'b0;
      if (f == 0) begin
      end else if (!f[11] && f[0]) begin
         if (imm == 0) e_ill = 1'b1;
         else nvl = (int'(rf[imm]) < exp_max) ? int'(rf[imm]) : exp_max;
      end else if (!f[11]) begin
         nvl = imm + 1; e_ill = (imm + 1) > XL;
      end else if (!f[0]) begin
         nmax = imm + 1; nvl = imm + 1; e_ill = (imm + 1) > XL;
      end else begin
         nmax = imm + 1; nvl = (exp_vl > nmax) ? nmax : exp_vl; e_ill = (imm + 1) > XL;
      end
      if (e_ill) begin nmax = exp_max; nvl = exp_vl; end
      e_wr = !e_ill && f != 0 && dst != 0;
      e_st = {20'd0, 6'(nvl), 6'(nmax)};

      @(negedge clk); valid = 1'b1; lt = f;
      check(rd_addr == f[5:1], {tag, " R2 read address"}, 64'(rd_addr), 64'(f[5:1]));
      @(negedge clk); valid = 1'b0; mid_done = done;
      @(negedge clk);
      check(!mid_done && done, {tag, " R2 done timing"}, {mid_done, done}, 64'b01);
      check(ill == e_ill && st == e_st, tag, {ill, st}, {e_ill, e_st});
      check(wr_en == e_wr && (!e_wr || (wr_addr == 5'(dst) && wr_data == XL'(nvl))),
            {tag, " R9 write"}, {wr_en, wr_addr, wr_data}, {e_wr, 5'(dst), XL'(nvl)});
      check(o_done && o_ill == (f != 0) && o_st == 0 && !o_wr_en, {tag, " R11 disabled"},
            {o_done, o_ill, o_wr_en, o_st}, {1'b1, f != 0, 1'b0, 32'd0});
      @(negedge clk); after_done = done;
      check(!after_done, {tag, " R2 single pulse"}, 64'(after_done), 64'd0);
      exp_max = nmax; exp_vl = nvl;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int r = 0; r < 32; r++) rf[r] = '0;
      rd_q = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(st == 0 && !done && !ill && !wr_en, "R1 reset state", {done, ill, wr_en, st}, 64'd0);

      run_op(12'h000, "R3 zero field at reset");
      // R6 and R8: one-off sweep, upper half traps
      for (int i = 0; i < 32; i++) run_op({1'b1, 5'(i), 5'(i), 1'b0}, "R6/R8/R9 one-off");
      // R4: loop immediate sweep
      for (int i = 0; i < 32; i++) run_op({1'b0, 5'((i * 3) % 32), 5'(i), 1'b0}, "R4/R8 loop imm");
      // R7: clamp against a range of current lengths
      run_op({1'b1, 5'd0, 5'd15, 1'b0}, "R6 set 16");
      for (int i = 0; i < 32; i++) begin
         run_op({1'b0, 5'd0, 5'((i * 5) % 16), 1'b0}, "R4 prep");
         run_op({1'b1, 5'(i % 7), 5'(i), 1'b1}, "R7/R8 max only");
      end
      run_op(12'h000, "R3 zero field keeps state");
      // R5: register mode
      for (int r = 1; r < 32; r++) rf[r] = XL'((r * 7) % 40);
      run_op({1'b1, 5'd0, 5'd13, 1'b0}, "R6 set 14");
      run_op({1'b0, 5'd0, 5'd0, 1'b1}, "R5 register zero illegal");
      for (int r = 1; r < 32; r++) run_op({1'b0, 5'd0, 5'(r), 1'b1}, "R5 register mode");
      run_op({1'b0, 5'd9, 5'd9, 1'b1}, "R5/R9 register mode same dest");
      run_op({1'b0, 5'd9, 5'd9, 1'b1}, "R5 reread written register");
      check(st[31:12] == 0, "R10 offsets and upper bits", 64'(st[31:12]), 64'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule